// File: doc/BRIEF.md
# Glitch-free multi-bank clock divider

This block derives three banks of divided clocks (A, B and C, four outputs each) and one feedback clock from a single fast clock. The fast clock stands in for an oscillator, and the block counts its cycles. A global select chooses whether the fast clock is used directly or halved first. Each bank has its own 2-bit ratio select that picks from a ratio set of its own. The feedback output has its own 2-bit select. One control inverts the upper two bank-C outputs.

Any select, the invert control or a per-output run enable may change at any time while the block runs. Each divider keeps its ratio, its invert setting and its enables in registers. It takes new values only at the end of a full period, when its output is low and its count is spent. This means an output never shows a cycle shorter or longer than both the old and the new period. Output QC0 and the feedback output cannot be stopped. This keeps the feedback loop from locking up because of a bad enable word.

Top module: `mbc_clkgen`

## Requirements
- R1: With `fast_direct` high, bank A divides the fast clock by 2, 6, 4 and 12 for `sel_a` codes 00, 01, 10 and 11.
- R2: With `fast_direct` high, bank B divides by 2, 6, 4 and 10 for `sel_b` codes 00, 01, 10 and 11.
- R3: With `fast_direct` high, bank C divides by 8, 2, 6 and 4 for `sel_c` codes 00, 01, 10 and 11.
- R4: With `fast_direct` high, `fb_out` divides by 4, 6, 8 and 10 for `sel_fb` codes 00, 01, 10 and 11.
- R5: With `fast_direct` low, every ratio of R1 to R4 is doubled.
- R6: While `inv_c` is high (as latched at a period start), `qc[2]` and `qc[3]` carry the complement of the bank-C clock; `qc[0]` and `qc[1]` never invert.
- R7: A ratio, pre-divide or invert change takes effect only at the next period start of that divider, so every output period is either a full old period or a full new period.
- R8: `run_en` bit 0..3 enable `qa[0..3]`, bits 4..7 enable `qb[0..3]`, bits 8..10 enable `qc[1..3]`. An enable is sampled at a period start. A disabled output holds low for whole periods. `qc[0]` and `fb_out` are always running.
- R9: While `rst_n` is low at a clock edge, all outputs are low after that edge.
- R10: On the first clock edge with `rst_n` high, every enabled, non-inverted output goes high together, so all banks start aligned.
- R11: Every output period is high for exactly half of its length in fast-clock cycles, followed by an equal low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that all dividers count |
| rst_n | input | 1 | Synchronous active-low master reset |
| fast_direct | input | 1 | High: count the fast clock directly; low: double every ratio |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 2 | Feedback ratio code |
| inv_c | input | 1 | Invert `qc[2]` and `qc[3]` |
| run_en | input | 11 | Per-output run enables (mapping in R8) |
| qa | output | 4 | Bank A clocks |
| qb | output | 4 | Bank B clocks |
| qc | output | 4 | Bank C clocks |
| fb_out | output | 1 | Feedback clock |

## Verification
The enable-rise check assumes that a non-inverted output can rise only at a period start, where its enable was just sampled. For that reason it covers `qa`, `qb` and `qc[1]`, and leaves out the inverted pair. The duty checks on `qc[0]` and `fb_out` assume those two outputs are never gated, which holds by the port mapping. Selects, enables and `inv_c` are driven on the falling edge so that they are stable at every rising edge. They change at odd offsets, including bursts only a few cycles apart, so many updates are discarded before a boundary.

// File: rtl/mbc_pkg.sv
// Shared types and ratio tables for the multi-bank clock divider.
// Assumes ratios are even, so each period splits into equal half periods.
package mbc_pkg;

    typedef enum logic [1:0] {
        BK_A  = 2'd0,
        BK_B  = 2'd1,
        BK_C  = 2'd2,
        BK_FB = 2'd3
    } bank_kind_e;

    // Largest half period after the optional doubling (bank A code 11: 24/2).
    localparam int MAX_HALF = 12;
    localparam int HALF_W   = $clog2(MAX_HALF + 1);

    // Half period in fast-clock cycles with the fast clock used directly.
    function automatic logic [HALF_W-1:0] base_half(bank_kind_e kind, logic [1:0] code);
        logic [HALF_W-1:0] h;
        unique case (kind)
            BK_A: begin
                case (code)
                    2'b00: h = HALF_W'(1);
                    2'b01: h = HALF_W'(3);
                    2'b10: h = HALF_W'(2);
                    default: h = HALF_W'(6);
                endcase
            end
            BK_B: begin
                case (code)
                    2'b00: h = HALF_W'(1);
                    2'b01: h = HALF_W'(3);
                    2'b10: h = HALF_W'(2);
                    default: h = HALF_W'(5);
                endcase
            end
            BK_C: begin
                case (code)
                    2'b00: h = HALF_W'(4);
                    2'b01: h = HALF_W'(1);
                    2'b10: h = HALF_W'(3);
                    default: h = HALF_W'(2);
                endcase
            end
            default: begin
                case (code)
                    2'b00: h = HALF_W'(2);
                    2'b01: h = HALF_W'(3);
                    2'b10: h = HALF_W'(4);
                    default: h = HALF_W'(5);
                endcase
            end
        endcase
        return h;
    endfunction

endpackage

// File: rtl/mbc_ratio_map.sv
// Maps a bank's ratio code and the pre-divide select to a half period.
// Assumes the package tables give a nonzero half period for each code.
module mbc_ratio_map #(
    parameter mbc_pkg::bank_kind_e KIND = mbc_pkg::BK_A,
    parameter int HW = mbc_pkg::HALF_W
) (
    input  logic [1:0]    code,
    input  logic          fast_direct,
    output logic [HW-1:0] half
);
    logic [HW-1:0] base;

    // Table lookup, then doubled when the fast clock is halved first.
    always_comb begin
        base = HW'(mbc_pkg::base_half(KIND, code));
        half = fast_direct ? base : (base << 1);
    end
endmodule

// File: rtl/mbc_div_core.sv
// Even-ratio counter: high phase, then low phase, each of a latched length.
// A new half period is taken only at period start (low phase, count spent).
// Assumes half_in is never zero.
module mbc_div_core #(
    parameter int HW = mbc_pkg::HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] half_in,
    output logic          phase,
    output logic          restart
);
    logic [HW-1:0] cnt_q;
    logic [HW-1:0] half_q;
    logic          phase_q;

    // Period start: the low phase has run out.
    assign restart = !phase_q && (cnt_q == '0);
    assign phase   = phase_q;

    // Counts down each half period and latches a new length at period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
            half_q  <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (phase_q) begin
            phase_q <= 1'b0;
            cnt_q   <= half_q - 1'b1;
        end else begin
            phase_q <= 1'b1;
            half_q  <= half_in;
            cnt_q   <= half_in - 1'b1;
        end
    end
endmodule

// File: rtl/mbc_out_gate.sv
// One output: enable and invert are latched at period start, so a
// frozen output is removed or restored only for whole periods.
// Assumes load pulses on the same edge the divider starts a period.
module mbc_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic phase,
    input  logic en,
    input  logic inv,
    output logic q
);
    logic gate_q;
    logic inv_q;

    // Latches enable and invert at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            inv_q  <= 1'b0;
        end else if (load) begin
            gate_q <= en;
            inv_q  <= inv;
        end
    end

    // Output is low whenever gated off.
    assign q = gate_q & (phase ^ inv_q);
endmodule

// File: rtl/mbc_bank.sv
// One bank: a ratio lookup, one divider core and NOUT output gates.
// INV_MASK selects which outputs follow the invert input.
module mbc_bank #(
    parameter mbc_pkg::bank_kind_e KIND = mbc_pkg::BK_A,
    parameter int NOUT     = 4,
    parameter int HW       = mbc_pkg::HALF_W,
    parameter logic [NOUT-1:0] INV_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      code,
    input  logic            fast_direct,
    input  logic [NOUT-1:0] en,
    input  logic            inv,
    output logic [NOUT-1:0] q
);
    logic [HW-1:0] half_new;
    logic          phase;
    logic          restart;

    mbc_ratio_map #(.KIND(KIND), .HW(HW)) i_map (
        .code        (code),
        .fast_direct (fast_direct),
        .half        (half_new)
    );

    mbc_div_core #(.HW(HW)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_in (half_new),
        .phase   (phase),
        .restart (restart)
    );

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        mbc_out_gate i_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (restart),
            .phase (phase),
            .en    (en[i]),
            .inv   (inv & INV_MASK[i]),
            .q     (q[i])
        );
    end
endmodule

// File: rtl/mbc_clkgen.sv
// Top: three four-output banks plus a feedback divider, all from clk.
// QC0 and the feedback output are tied enabled so they cannot be frozen.
// Assumes selects and enables are synchronous to clk.
module mbc_clkgen #(
    parameter int BANK_W = 4,
    parameter int HW     = mbc_pkg::HALF_W,
    localparam int EN_W  = 3 * BANK_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_direct,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic [1:0]        sel_c,
    input  logic [1:0]        sel_fb,
    input  logic              inv_c,
    input  logic [EN_W-1:0]   run_en,
    output logic [BANK_W-1:0] qa,
    output logic [BANK_W-1:0] qb,
    output logic [BANK_W-1:0] qc,
    output logic              fb_out
);
    localparam logic [BANK_W-1:0] C_INV = {2'b11, {(BANK_W-2){1'b0}}};

    logic [BANK_W-1:0] en_c;
    logic [0:0]        fb_q;

    // Bank C bit 0 is always running.
    assign en_c = {run_en[EN_W-1:2*BANK_W], 1'b1};

    mbc_bank #(.KIND(mbc_pkg::BK_A), .NOUT(BANK_W), .HW(HW), .INV_MASK('0)) i_bank_a (
        .clk (clk), .rst_n (rst_n), .code (sel_a), .fast_direct (fast_direct),
        .en (run_en[BANK_W-1:0]), .inv (1'b0), .q (qa)
    );

    mbc_bank #(.KIND(mbc_pkg::BK_B), .NOUT(BANK_W), .HW(HW), .INV_MASK('0)) i_bank_b (
        .clk (clk), .rst_n (rst_n), .code (sel_b), .fast_direct (fast_direct),
        .en (run_en[2*BANK_W-1:BANK_W]), .inv (1'b0), .q (qb)
    );

    mbc_bank #(.KIND(mbc_pkg::BK_C), .NOUT(BANK_W), .HW(HW), .INV_MASK(C_INV)) i_bank_c (
        .clk (clk), .rst_n (rst_n), .code (sel_c), .fast_direct (fast_direct),
        .en (en_c), .inv (inv_c), .q (qc)
    );

    mbc_bank #(.KIND(mbc_pkg::BK_FB), .NOUT(1), .HW(HW), .INV_MASK(1'b0)) i_bank_fb (
        .clk (clk), .rst_n (rst_n), .code (sel_fb), .fast_direct (fast_direct),
        .en (1'b1), .inv (1'b0), .q (fb_q)
    );

    assign fb_out = fb_q[0];
endmodule

// File: rtl/mbc_clkgen_chk.sv
// Port-level checker for mbc_clkgen: reset state, aligned start,
// enable sampling and equal half periods on the two unstoppable outputs.
module mbc_clkgen_chk #(
    parameter int BANK_W = 4,
    localparam int EN_W  = 3 * BANK_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [EN_W-1:0]   run_en,
    input logic [BANK_W-1:0] qa,
    input logic [BANK_W-1:0] qb,
    input logic [BANK_W-1:0] qc,
    input logic              fb_out
);
    localparam int NG = 2 * BANK_W + 1;

    logic [1:0] sig;
    logic [1:0] prev;
    logic [7:0] run   [2];
    logic [7:0] hi_len[2];
    logic [1:0] hi_ok;
    logic [NG-1:0] gated_q;

    assign sig     = {fb_out, qc[0]};
    assign gated_q = {qc[1], qb, qa};

    // Measures high and low run lengths of qc[0] and fb_out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev  <= '0;
            hi_ok <= '0;
            for (int k = 0; k < 2; k++) begin
                run[k]    <= '0;
                hi_len[k] <= '0;
            end
        end else begin
            prev <= sig;
            for (int k = 0; k < 2; k++) begin
                if (sig[k] != prev[k]) begin
                    if (!sig[k]) begin
                        hi_len[k] <= run[k];
                        hi_ok[k]  <= 1'b1;
                    end
                    run[k] <= 8'd1;
                end else begin
                    run[k] <= run[k] + 8'd1;
                end
            end
        end
    end

    // R9
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (qa == '0 && qb == '0 && qc == '0 && !fb_out));

    // R10
    aligned_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (qc[0] && fb_out));

    // R11
    duty_qc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig[0] && !prev[0] && hi_ok[0]) |-> (run[0] == hi_len[0]));

    // R11
    duty_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig[1] && !prev[1] && hi_ok[1]) |-> (run[1] == hi_len[1]));

    for (genvar i = 0; i < NG; i++) begin : g_en
        // R8
        rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gated_q[i]) |-> $past(run_en[i]));
    end
endmodule

bind mbc_clkgen mbc_clkgen_chk #(.BANK_W(BANK_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .qa     (qa),
    .qb     (qb),
    .qc     (qc),
    .fb_out (fb_out)
);

// File: tb/test_mbc_clkgen.sv
`timescale 1ns/1ps
module test_mbc_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_direct = 1'b1;
    logic [1:0]  sel_a = 2'b00, sel_b = 2'b00, sel_c = 2'b00, sel_fb = 2'b00;
    logic        inv_c = 1'b0;
    logic [10:0] run_en = 11'h7ff;
    logic [3:0]  qa, qb, qc;
    logic        fb_out;

    int errors = 0;
    int checks = 0;
    string cur_req = "R9";
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbc_clkgen i_mbc_clkgen (
        .clk (clk), .rst_n (rst_n), .fast_direct (fast_direct),
        .sel_a (sel_a), .sel_b (sel_b), .sel_c (sel_c), .sel_fb (sel_fb),
        .inv_c (inv_c), .run_en (run_en),
        .qa (qa), .qb (qb), .qc (qc), .fb_out (fb_out)
    );

    // Ratio sets taken from R1-R4, doubled per R5.
    function automatic int half_of(int bank, int code, bit direct);
        int ra[4] = '{2, 6, 4, 12};
        int rb[4] = '{2, 6, 4, 10};
        int rc[4] = '{8, 2, 6, 4};
        int rf[4] = '{4, 6, 8, 10};
        int r;
        case (bank)
            0: r = ra[code];
            1: r = rb[code];
            2: r = rc[code];
            default: r = rf[code];
        endcase
        return direct ? r / 2 : r;
    endfunction

    // Behavioural model: position within period, latched at period start.
    int pos[4] = '{0, 0, 0, 0};
    int hh[4]  = '{1, 1, 1, 1};
    logic [3:0] gA = '0, gB = '0, gC = '0;
    logic invL = 1'b0;
    logic [3:0] ex_a = '0, ex_b = '0, ex_c = '0;
    logic ex_fb = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) pos[b] = 0;
            gA = '0; gB = '0; gC = '0; invL = 1'b0;
            ex_a = '0; ex_b = '0; ex_c = '0; ex_fb = 1'b0;
        end else begin
            logic [3:0] base;
            int codes[4];
            codes[0] = sel_a; codes[1] = sel_b; codes[2] = sel_c; codes[3] = sel_fb;
            for (int b = 0; b < 4; b++) begin
                if (pos[b] == 0) begin
                    hh[b] = half_of(b, codes[b], fast_direct);
                    if (b == 0) gA = run_en[3:0];
                    if (b == 1) gB = run_en[7:4];
                    if (b == 2) begin
                        gC = {run_en[10:8], 1'b1};
                        invL = inv_c;
                    end
                end
                base[b] = (pos[b] < hh[b]);
                pos[b]++;
                if (pos[b] == 2 * hh[b]) pos[b] = 0;
            end
            ex_a  = base[0] ? gA : 4'b0;
            ex_b  = base[1] ? gB : 4'b0;
            ex_c  = gC & ({4{base[2]}} ^ {invL, invL, 2'b00});
            ex_fb = base[3];
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            checks++;
            if (qa !== ex_a || qb !== ex_b || qc !== ex_c || fb_out !== ex_fb) begin
                errors++;
                $display("FAIL %s: actual qa=%h qb=%h qc=%h fb=%b expected qa=%h qb=%h qc=%h fb=%b at %0t",
                         cur_req, qa, qb, qc, fb_out, ex_a, ex_b, ex_c, ex_fb, $time);
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        run(5);
        // R9: outputs low in reset
        chk("R9", {qa, qb, qc, fb_out}, 0);
        model_on = 1'b1;
        rst_n = 1'b1;
        run(1);
        // R10: aligned start, every output high
        chk("R10", {qa, qb, qc, fb_out}, 13'h1fff);
        cur_req = "R1";
        run(40);
        // R1-R4 with fast clock direct, on-the-fly code walk
        for (int c = 0; c < 4; c++) begin
            cur_req = "R1"; sel_a = 2'(c); run(37);
            cur_req = "R2"; sel_b = 2'(c); run(41);
            cur_req = "R3"; sel_c = 2'(c); run(29);
            cur_req = "R4"; sel_fb = 2'(c); run(43);
        end
        // R5: halved fast clock
        cur_req = "R5";
        fast_direct = 1'b0;
        for (int c = 0; c < 4; c++) begin
            sel_a = 2'(3 - c); sel_b = 2'(c); sel_c = 2'(c ^ 1); sel_fb = 2'(c ^ 2);
            run(61);
        end
        // R11: bank A /24 -> 12 high, 12 low
        cur_req = "R11";
        sel_a = 2'b11;
        run(60);
        while (qa[0]) run(1);
        while (!qa[0]) run(1);
        begin
            int hi = 0;
            int lo = 0;
            while (qa[0]) begin hi++; run(1); end
            while (!qa[0]) begin lo++; run(1); end
            chk("R11", hi, 12);
            chk("R11", lo, 12);
        end
        // R6: inversion of qc[3:2]
        cur_req = "R6";
        fast_direct = 1'b1; sel_c = 2'b01;
        inv_c = 1'b1;
        run(30);
        for (int k = 0; k < 4; k++) begin
            chk("R6", {qc[3], qc[2]}, {2{~qc[1]}});
            chk("R6", qc[0], qc[1]);
            run(1);
        end
        inv_c = 1'b0;
        run(30);
        chk("R6", {qc[3], qc[2]}, {qc[1], qc[1]});
        // R8: freeze patterns
        cur_req = "R8";
        sel_a = 2'b00; sel_b = 2'b00; sel_c = 2'b00;
        run_en = 11'h000;
        inv_c = 1'b1;
        run(40);
        begin
            int seen_a = 0;
            int rises = 0;
            for (int k = 0; k < 16; k++) begin
                seen_a |= {qa, qb, qc[3:1]};
                if (qc[0]) rises++;
                run(1);
            end
            chk("R8", seen_a, 0);
            chk("R8", (rises > 0), 1);
        end
        run_en = 11'h5a3; run(33);
        run_en = 11'h2dc; run(27);
        inv_c = 1'b0;
        run_en = 11'h7ff; run(40);
        // R7: rapid select changes, many discarded before a boundary
        cur_req = "R7";
        for (int k = 0; k < 60; k++) begin
            sel_a = 2'((k * 3) % 4); sel_b = 2'((k * 5 + 1) % 4);
            sel_c = 2'((k * 7 + 2) % 4); sel_fb = 2'(k % 4);
            if (k % 9 == 0) fast_direct = ~fast_direct;
            if (k % 5 == 0) inv_c = ~inv_c;
            run(1 + (k % 7));
        end
        run(60);
        // R9/R10: reset mid-run, then aligned restart
        cur_req = "R9";
        rst_n = 1'b0;
        run(3);
        chk("R9", {qa, qb, qc, fb_out}, 0);
        inv_c = 1'b0; run_en = 11'h7ff;
        rst_n = 1'b1;
        run(1);
        chk("R10", {qa, qb, qc, fb_out}, 13'h1fff);
        cur_req = "R10";
        run(50);
        finish_up();
    end
endmodule